// File: doc/BRIEF.md
# Clock Strap Latch and Gating Controller

This block is the control core of a multi-output clock generator. After power-on reset it watches the supply-ready indication. It treats the shared strap/clock pins as inputs until that indication first goes high. In that cycle it captures the four frequency-select straps and the pin-mode strap. It then turns the shared pins into outputs held low and counts reference ticks. When the power-up count ends, it releases every output at once. The analog parts (PLL, dividers, spread modulation) sit outside and follow the controls produced here.

After release, the block chooses the frequency code. This is either the zero-extended strap code or a six-bit code from software. It also computes one gate enable per clock output from several inputs: the per-output and per-bank stop bits, the power-down pin and the latched pin mode. Each gate enable changes only while its clock is reported low, so stopping or restarting an output never cuts a pulse short. A global tristate control and a readback of the captured straps complete the block.

Top module: `clkstrap_ctrl`

## Requirements
- R1: After reset, `strap_oe` and `strap_drive_low` stay 0 until `supply_ok` is seen high at a clock edge. At that edge `strap_fs` and `strap_mode` are captured, and from the next cycle `strap_oe` is 1.
- R2: Once captured, strap values stay fixed until `rst_n` is asserted again. Later changes on `strap_fs`, `strap_mode` or `supply_ok` have no effect on `strap_status`, `ref0_is_output` or `freq_code`.
- R3: From capture, `strap_drive_low` is 1 and every `gate_en` bit is 0. The ticks counted are edges with `ref_tick` high while `strap_drive_low` is 1. On the edge that counts the PU_TICKS-th such tick, `strap_drive_low` falls and `pu_done` pulses high for exactly one cycle.
- R4: `ref0_is_output` equals the captured mode strap. With mode 1, output REF0_IDX may run and `pd_n` is ignored. With mode 0, output REF0_IDX is never enabled and `pd_n` acts as active-low power-down.
- R5: While power-down is active (mode strap 0 and `pd_n` low), every output other than FREE_IDX is stopped. Output FREE_IDX keeps following its own enable.
- R6: One cycle after a clock edge, `freq_code` holds the value chosen at that edge. It is `cfg_sw_code` when `cfg_sw_sel` is 1. When `cfg_sw_sel` is 0, it is the captured four-bit strap code in bits 3:0 with bits 5:4 zero.
- R7: `out_hiz` equals `cfg_tristate` as registered at the previous clock edge. 1 means all outputs float.
- R8: Output i < NUM_SINGLE is enabled by `cfg_en_single[i]`. Output NUM_SINGLE + b*BANK_W + k (0 ≤ k < BANK_W) is enabled by `cfg_en_bank[b]`. A 1 means run and a 0 means stop. Outputs can run only after `pu_done`.
- R9: Bit i of `gate_en` changes at a clock edge only when `out_low[i]` was 1 at that edge. Otherwise it keeps its value.
- R10: `strap_status` bits 6:3 hold the captured frequency straps (`strap_fs[3]` in bit 6). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low power-on reset |
| supply_ok | input | 1 | Supply has reached its capture level |
| strap_fs | input | 4 | Frequency-select strap levels from the shared pins |
| strap_mode | input | 1 | Pin-mode strap level |
| ref_tick | input | 1 | One-cycle tick from the reference clock for the power-up timer |
| cfg_sw_sel | input | 1 | 1 selects the software frequency code |
| cfg_tristate | input | 1 | 1 floats all clock outputs |
| cfg_sw_code | input | 6 | Software frequency code |
| cfg_en_single | input | NUM_SINGLE | Run enables for individually gated outputs |
| cfg_en_bank | input | NUM_BANK | Run enables for the banks of memory clocks |
| pd_n | input | 1 | Power-down pin level (active low when mode strap is 0) |
| out_low | input | NUM_SINGLE+NUM_BANK*BANK_W | Per-output flag: that clock is currently low |
| strap_oe | output | 1 | Shared pins are outputs |
| strap_drive_low | output | 1 | Shared pins are forced low (power-up wait) |
| pu_done | output | 1 | One-cycle pulse when the power-up timer ends |
| ref0_is_output | output | 1 | Shared pin is the reference clock output, not power-down |
| freq_code | output | 6 | Selected frequency table index |
| strap_status | output | 8 | Readback of captured straps |
| gate_en | output | NUM_SINGLE+NUM_BANK*BANK_W | Per-output gate enable |
| out_hiz | output | 1 | Tristate all clock outputs |

## Verification
The tricky overlap is a change in desired state and the low-phase window landing on the same edge. One case is a stop request raised, or power-down asserted, in the same cycle as that output's `out_low`. The other is a request made while the clock is high, which must wait. The bench drives the enables, `pd_n` and `out_low` with independent random patterns, so all these combinations arise many times. A behavioural model decides for every output and every cycle whether the gate may move. A second overlap is the final timer tick falling in a cycle where software changes the enables. The model checks that no output opens before the cycle after the release.

// File: rtl/clkstrap_pkg.sv
package clkstrap_pkg;
    localparam int FS_W   = 4;
    localparam int CODE_W = 6;
    localparam int STAT_W = 8;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_HOLD = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;
endpackage

// File: rtl/clkstrap_latch.sv
module clkstrap_latch
    import clkstrap_pkg::*;
#(
    parameter int PU_TICKS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            supply_ok,
    input  logic [FS_W-1:0] strap_fs,
    input  logic            strap_mode,
    input  logic            ref_tick,
    output phase_e          phase,
    output logic [FS_W-1:0] fs_lat,
    output logic            mode_lat,
    output logic            done_pulse
);
    localparam int CNT_W = (PU_TICKS < 2) ? 1 : $clog2(PU_TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PU_TICKS - 1);

    typedef struct packed {
        phase_e          phase;
        logic [CNT_W-1:0] cnt;
        logic [FS_W-1:0] fs;
        logic            mode;
        logic            done;
    } latch_s;

    latch_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_WAIT: begin
                if (supply_ok) begin
                    st_d.phase = PH_HOLD;
                    st_d.fs    = strap_fs;
                    st_d.mode  = strap_mode;
                    st_d.cnt   = '0;
                end
            end
            PH_HOLD: begin
                if (ref_tick) begin
                    if (st_q.cnt == CNT_LAST) begin
                        st_d.phase = PH_RUN;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                st_d.phase = PH_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_WAIT, cnt: '0, fs: '0, mode: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase      = st_q.phase;
    assign fs_lat     = st_q.fs;
    assign mode_lat   = st_q.mode;
    assign done_pulse = st_q.done;

    // R1
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_WAIT && !supply_ok) |=> st_q.phase == PH_WAIT);

    // R2
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_WAIT) |=> ($stable(st_q.fs) && $stable(st_q.mode)));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
endmodule

// File: rtl/clkstrap_gate.sv
module clkstrap_gate #(
    parameter int NUM_SINGLE = 4,
    parameter int NUM_BANK   = 3,
    parameter int BANK_W     = 4,
    parameter int FREE_IDX   = 0,
    parameter int REF0_IDX   = 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  run,
    input  logic                                  pd_active,
    input  logic                                  ref0_out,
    input  logic [NUM_SINGLE-1:0]                 en_single,
    input  logic [NUM_BANK-1:0]                   en_bank,
    input  logic [NUM_SINGLE+NUM_BANK*BANK_W-1:0] out_low,
    output logic [NUM_SINGLE+NUM_BANK*BANK_W-1:0] gate_en
);
    localparam int NUM_OUT = NUM_SINGLE + NUM_BANK * BANK_W;

    typedef struct packed {
        logic [NUM_OUT-1:0] gate;
    } gate_s;

    gate_s gs_d, gs_q;
    logic [NUM_OUT-1:0] en_full;
    logic [NUM_OUT-1:0] want;

    for (genvar s = 0; s < NUM_SINGLE; s++) begin : g_single
        assign en_full[s] = en_single[s];
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        for (genvar k = 0; k < BANK_W; k++) begin : g_member
            assign en_full[NUM_SINGLE + b*BANK_W + k] = en_bank[b];
        end
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_want
        if (o == FREE_IDX) begin : g_free
            assign want[o] = run & en_full[o];
        end else if (o == REF0_IDX) begin : g_ref0
            assign want[o] = run & en_full[o] & ref0_out & ~pd_active;
        end else begin : g_plain
            assign want[o] = run & en_full[o] & ~pd_active;
        end
    end

    always_comb begin
        gs_d = gs_q;
        for (int o = 0; o < NUM_OUT; o++) begin
            if (out_low[o]) begin
                gs_d.gate[o] = want[o];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gs_q <= '0;
        end else begin
            gs_q <= gs_d;
        end
    end

    assign gate_en = gs_q.gate;

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
        // R9
        glitch_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !out_low[o] |=> gs_q.gate[o] == $past(gs_q.gate[o]));
    end
endmodule

// File: rtl/clkstrap_ctrl.sv
module clkstrap_ctrl
    import clkstrap_pkg::*;
#(
    parameter int NUM_SINGLE = 4,
    parameter int NUM_BANK   = 3,
    parameter int BANK_W     = 4,
    parameter int FREE_IDX   = 0,
    parameter int REF0_IDX   = 1,
    parameter int PU_TICKS   = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  supply_ok,
    input  logic [3:0]                            strap_fs,
    input  logic                                  strap_mode,
    input  logic                                  ref_tick,
    input  logic                                  cfg_sw_sel,
    input  logic                                  cfg_tristate,
    input  logic [5:0]                            cfg_sw_code,
    input  logic [NUM_SINGLE-1:0]                 cfg_en_single,
    input  logic [NUM_BANK-1:0]                   cfg_en_bank,
    input  logic                                  pd_n,
    input  logic [NUM_SINGLE+NUM_BANK*BANK_W-1:0] out_low,
    output logic                                  strap_oe,
    output logic                                  strap_drive_low,
    output logic                                  pu_done,
    output logic                                  ref0_is_output,
    output logic [5:0]                            freq_code,
    output logic [7:0]                            strap_status,
    output logic [NUM_SINGLE+NUM_BANK*BANK_W-1:0] gate_en,
    output logic                                  out_hiz
);
    phase_e          phase;
    logic [FS_W-1:0] fs_lat;
    logic            mode_lat;
    logic            pd_active;

    typedef struct packed {
        logic [CODE_W-1:0] freq;
        logic              hiz;
    } sel_s;

    sel_s sel_d, sel_q;

    clkstrap_latch #(
        .PU_TICKS(PU_TICKS)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .strap_fs   (strap_fs),
        .strap_mode (strap_mode),
        .ref_tick   (ref_tick),
        .phase      (phase),
        .fs_lat     (fs_lat),
        .mode_lat   (mode_lat),
        .done_pulse (pu_done)
    );

    assign pd_active = ~mode_lat & ~pd_n;

    clkstrap_gate #(
        .NUM_SINGLE (NUM_SINGLE),
        .NUM_BANK   (NUM_BANK),
        .BANK_W     (BANK_W),
        .FREE_IDX   (FREE_IDX),
        .REF0_IDX   (REF0_IDX)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (phase == PH_RUN),
        .pd_active (pd_active),
        .ref0_out  (mode_lat),
        .en_single (cfg_en_single),
        .en_bank   (cfg_en_bank),
        .out_low   (out_low),
        .gate_en   (gate_en)
    );

    always_comb begin
        sel_d     = sel_q;
        sel_d.hiz = cfg_tristate;
        if (cfg_sw_sel) begin
            sel_d.freq = cfg_sw_code;
        end else begin
            sel_d.freq = {{(CODE_W-FS_W){1'b0}}, fs_lat};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign strap_oe        = (phase != PH_WAIT);
    assign strap_drive_low = (phase == PH_HOLD);
    assign ref0_is_output  = mode_lat;
    assign freq_code       = sel_q.freq;
    assign out_hiz         = sel_q.hiz;
    assign strap_status    = {1'b0, fs_lat, 3'b000};

    // R3
    hold_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strap_drive_low |-> gate_en == '0);

    // R6
    sw_code_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sw_sel |=> freq_code == $past(cfg_sw_code));

    // R7
    hiz_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_hiz == $past(cfg_tristate));

    // R5
    pd_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_lat && !pd_n && out_low[REF0_IDX]) |=> !gate_en[REF0_IDX]);
endmodule

// File: tb/tb_clkstrap_ctrl.sv
`timescale 1ns/1ps
module tb_clkstrap_ctrl;
    localparam int NS = 4, NB = 3, BW = 4, NO = NS + NB*BW;
    localparam int FREE = 0, REF0 = 1, PUT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic [3:0] strap_fs = '0;
    logic strap_mode = 1'b0;
    logic ref_tick = 1'b0;
    logic cfg_sw_sel = 1'b0;
    logic cfg_tristate = 1'b0;
    logic [5:0] cfg_sw_code = '0;
    logic [NS-1:0] cfg_en_single = '1;
    logic [NB-1:0] cfg_en_bank = '1;
    logic pd_n = 1'b1;
    logic [NO-1:0] out_low = '0;
    logic strap_oe, strap_drive_low, pu_done, ref0_is_output, out_hiz;
    logic [5:0] freq_code;
    logic [7:0] strap_status;
    logic [NO-1:0] gate_en;

    always #2.5 clk = ~clk;

    clkstrap_ctrl #(.NUM_SINGLE(NS), .NUM_BANK(NB), .BANK_W(BW),
                    .FREE_IDX(FREE), .REF0_IDX(REF0), .PU_TICKS(PUT)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .strap_fs(strap_fs),
        .strap_mode(strap_mode), .ref_tick(ref_tick), .cfg_sw_sel(cfg_sw_sel),
        .cfg_tristate(cfg_tristate), .cfg_sw_code(cfg_sw_code),
        .cfg_en_single(cfg_en_single), .cfg_en_bank(cfg_en_bank), .pd_n(pd_n),
        .out_low(out_low), .strap_oe(strap_oe), .strap_drive_low(strap_drive_low),
        .pu_done(pu_done), .ref0_is_output(ref0_is_output), .freq_code(freq_code),
        .strap_status(strap_status), .gate_en(gate_en), .out_hiz(out_hiz));

    // behavioural reference model
    int m_phase;          // 0 waiting, 1 holding low, 2 running
    int m_ticks;
    logic [3:0] m_fs;
    logic m_mode, m_done, m_hiz;
    logic [5:0] m_freq;
    logic [NO-1:0] m_gate;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    function automatic bit model_wants(int o);
        bit en, pd;
        if (m_phase != 2) return 0;
        en = (o < NS) ? cfg_en_single[o] : cfg_en_bank[(o - NS) / BW];
        pd = !m_mode && !pd_n;
        if (o == FREE) return en;
        if (o == REF0 && !m_mode) return 0;
        return en && !pd;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_ticks = 0; m_fs = '0; m_mode = 0;
            m_done = 0; m_hiz = 0; m_freq = '0; m_gate = '0;
        end else begin
            logic [NO-1:0] ng;
            int np; int nt; logic nd;
            logic [3:0] nfs; logic nmode;
            for (int o = 0; o < NO; o++) ng[o] = out_low[o] ? model_wants(o) : m_gate[o];
            np = m_phase; nt = m_ticks; nd = 0; nfs = m_fs; nmode = m_mode;
            if (m_phase == 0 && supply_ok) begin
                np = 1; nt = 0; nfs = strap_fs; nmode = strap_mode;
            end else if (m_phase == 1 && ref_tick) begin
                nt = m_ticks + 1;
                if (nt == PUT) begin np = 2; nd = 1; end
            end
            m_freq = cfg_sw_sel ? cfg_sw_code : {2'b00, m_fs};
            m_hiz = cfg_tristate;
            m_gate = ng; m_phase = np; m_ticks = nt; m_done = nd;
            m_fs = nfs; m_mode = nmode;
        end
    end

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
        end
    endtask

    task automatic check_all();
        cmp("R1", "strap_oe", 32'(strap_oe), 32'(m_phase != 0));
        cmp("R3", "strap_drive_low", 32'(strap_drive_low), 32'(m_phase == 1));
        cmp("R3", "pu_done", 32'(pu_done), 32'(m_done));
        cmp("R4", "ref0_is_output", 32'(ref0_is_output), 32'(m_mode));
        cmp("R6", "freq_code", 32'(freq_code), 32'(m_freq));
        cmp("R7", "out_hiz", 32'(out_hiz), 32'(m_hiz));
        cmp("R10", "strap_status", 32'(strap_status), 32'({1'b0, m_fs, 3'b000}));
        cmp("R8 R9 R5", "gate_en", 32'(gate_en), 32'(m_gate));
    endtask

    task automatic step(int pd_rate);
        @(negedge clk);
        check_all();
        ref_tick      = ($urandom % 3) == 0;
        cfg_sw_sel    = $urandom % 2;
        cfg_tristate  = ($urandom % 8) == 0;
        cfg_sw_code   = 6'($urandom);
        if (($urandom % 6) == 0) cfg_en_single = NS'($urandom);
        if (($urandom % 6) == 0) cfg_en_bank = NB'($urandom);
        pd_n          = ($urandom % pd_rate) != 0;
        out_low       = NO'($urandom);
    endtask

    task automatic power_cycle(logic [3:0] fs, logic mode);
        @(negedge clk);
        rst_n = 0; supply_ok = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all();
        cmp("R1", "reset gates", 32'(gate_en), 32'(0));
        rst_n = 1;
        for (int i = 0; i < 6; i++) begin
            strap_fs = 4'($urandom); strap_mode = $urandom % 2;
            step(4);
        end
        @(negedge clk);
        check_all();
        strap_fs = fs; strap_mode = mode; supply_ok = 1;
        @(negedge clk);
        check_all();
        // R2: strap pins and supply_ok wander after capture
        for (int i = 0; i < 400; i++) begin
            strap_fs = 4'($urandom); strap_mode = $urandom % 2;
            supply_ok = $urandom % 2;
            step((i < 200) ? 5 : 2);
        end
        cmp("R2", "captured strap readback", 32'(strap_status), 32'({1'b0, fs, 3'b000}));
        cmp("R4", "captured mode", 32'(ref0_is_output), 32'(mode));
    endtask

    initial begin
        power_cycle(4'b1011, 1'b0);
        power_cycle(4'b0110, 1'b1);
        power_cycle(4'b1111, 1'b0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule